// File: doc/BRIEF.md
# Memory Row Boundary Decoder

This block turns a physical address into a chip select for one of four memory rows. Software programs one 8-bit boundary value per row. Each value is the top of its row in units of 16 MB, so the byte is the address shifted right by 24. The rows are laid out end to end. Row 0 begins at address zero, and every later row begins where the highest boundary below it ends.

A row whose boundary does not rise above the boundaries beneath it holds no memory. Such a row is reported as empty and is never selected. An address that lies beyond every populated row raises a miss flag, and no chip select is driven for it.

The decode path is combinational, from the address input and the stored boundaries. Boundary writes are registered, so a write changes the decode from the cycle after the write.

Top module: `row_boundary_decoder`

## Requirements
- R1: While reset is held, and after it until the first write, all four boundaries read as 0. In that state `row_empty` = 4'b1111, `row_cs` = 4'b0000 and `miss` = 1 for any address.
- R2: A write with `wr_en`=1 stores `wr_byte` into the boundary of row `wr_row` (0 to 3) at the rising clock edge. In the write cycle itself, the decode still uses the old value. The new value governs the decode from the next cycle.
- R3: Row 0 covers addresses from 0 up to, but not including, boundary0 × 2^24. An address there drives `row_cs` = 4'b0001.
- R4: Row i (i ≥ 1) covers addresses from its base up to, but not including, boundary i × 2^24. Its base is the largest boundary among rows 0 to i-1, times 2^24. A hit drives bit i of `row_cs` alone.
- R5: Address bits 23:0 play no part in the decode. Only `addr[30:24]` is compared with the boundaries.
- R6: An address at or above the largest boundary × 2^24 sets `miss`=1 and `row_cs`=0. Otherwise `miss`=0 and exactly one `row_cs` bit is set.
- R7: A row whose boundary equals the largest boundary beneath it (boundary 0 for row 0) has its `row_empty` bit set, and its `row_cs` bit is never set.
- R8: A row whose boundary is below the largest boundary beneath it is also empty. The base of the rows above it stays at that largest boundary.
- R9: `row_cs` is at most one-hot, and it is zero exactly when `miss` is 1.
- R10: A boundary of 0x80 or more covers the whole 2 GB space. An address of 0x7FFF_FFFF then hits a row and does not miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Boundary write strobe |
| wr_row | input | 2 | Row whose boundary is written |
| wr_byte | input | 8 | New boundary value, in units of 16 MB |
| addr | input | 31 | Physical address to decode |
| row_cs | output | 4 | One-hot chip select, bit i for row i |
| miss | output | 1 | Address lies above every populated row |
| row_empty | output | 4 | Bit i set when row i holds no memory |

## Verification
The two functions that can meet in one cycle are a boundary write and a decode of an address that falls inside the row being rewritten. The bench drives both in the same cycle. Before the clock edge, it requires the chip select and miss flag to still reflect the old boundary. One cycle later, it requires them to reflect the new boundary.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int DEF_ROWS    = 4;
  localparam int DEF_LIMIT_W = 8;
  localparam int DEF_ADDR_W  = 31;
  localparam int DEF_GRAN    = 24;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rbd_reset_sync.sv
module rbd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/rbd_bound_regs.sv
module rbd_bound_regs #(
  parameter int ROWS    = 4,
  parameter int LIMIT_W = 8,
  localparam int SEL_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_int_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_row,
  input  logic [LIMIT_W-1:0]             wr_byte,
  output logic [ROWS-1:0][LIMIT_W-1:0]   lim_q
);
  logic [ROWS-1:0][LIMIT_W-1:0] lim_d;
  logic [ROWS-1:0]              lim_ce;

  always_comb begin
    for (int i = 0; i < ROWS; i++) begin
      lim_ce[i] = wr_en && (wr_row == SEL_W'(i));
      lim_d[i]  = wr_byte;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)    lim_q[g] <= '0;
      else if (lim_ce[g]) lim_q[g] <= lim_d[g];
    end
  end
endmodule

// File: rtl/rbd_row_window.sv
module rbd_row_window #(
  parameter int CMP_W = 8
) (
  input  logic [CMP_W-1:0] base,
  input  logic [CMP_W-1:0] limit,
  input  logic [CMP_W-1:0] addr_hi,
  output logic             hit,
  output logic             empty
);
  always_comb begin
    empty = (limit <= base);
    hit   = !empty && (addr_hi >= base) && (addr_hi < limit);
  end
endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder
  import rbd_pkg::*;
#(
  parameter int ROWS    = DEF_ROWS,
  parameter int LIMIT_W = DEF_LIMIT_W,
  parameter int ADDR_W  = DEF_ADDR_W,
  parameter int GRAN    = DEF_GRAN,
  localparam int SEL_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_row,
  input  logic [LIMIT_W-1:0] wr_byte,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ROWS-1:0]    row_cs,
  output logic               miss,
  output logic [ROWS-1:0]    row_empty
);
  localparam int HI_W  = ADDR_W - GRAN;
  localparam int CMP_W = imax(HI_W, LIMIT_W);

  logic                         rst_int_n;
  logic [ROWS-1:0][LIMIT_W-1:0] lim_q;
  logic [CMP_W-1:0]             addr_hi;
  logic [ROWS:0][CMP_W-1:0]     run_max;
  logic                         unused_addr_lo;

  assign unused_addr_lo = ^addr[GRAN-1:0];
  assign addr_hi        = CMP_W'(addr[ADDR_W-1:GRAN]);

  rbd_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  rbd_bound_regs #(.ROWS(ROWS), .LIMIT_W(LIMIT_W)) u_regs (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_byte   (wr_byte),
    .lim_q     (lim_q)
  );

  assign run_max[0] = '0;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [CMP_W-1:0] lim_ext;
    assign lim_ext = CMP_W'(lim_q[g]);
    assign run_max[g+1] = (lim_ext > run_max[g]) ? lim_ext : run_max[g];

    rbd_row_window #(.CMP_W(CMP_W)) u_win (
      .base    (run_max[g]),
      .limit   (lim_ext),
      .addr_hi (addr_hi),
      .hit     (row_cs[g]),
      .empty   (row_empty[g])
    );
  end

  assign miss = (addr_hi >= run_max[ROWS]);
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int ROWS   = 4,
  parameter int ADDR_W = 31,
  parameter int GRAN   = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [ROWS-1:0]   row_cs,
  input logic              miss,
  input logic [ROWS-1:0]   row_empty
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_cs)); // R9

  AST_MISS_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    miss == (row_cs == '0)); // R6

  AST_EMPTY_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (row_cs & row_empty) == '0); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(addr)) |=> ($stable(row_cs) && $stable(miss))); // R2

  AST_ROW0_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[ADDR_W-1:GRAN] == '0 && !row_empty[0]) |-> row_cs[0]); // R3
endmodule

bind row_boundary_decoder rbd_checker #(.ROWS(ROWS), .ADDR_W(ADDR_W), .GRAN(GRAN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .row_cs    (row_cs),
  .miss      (miss),
  .row_empty (row_empty)
);

// File: tb/sim_row_boundary_decoder.sv
`timescale 1ns/1ps
module sim_row_boundary_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_row;
  logic [7:0]  wr_byte;
  logic [30:0] addr;
  logic [3:0]  row_cs;
  logic        miss;
  logic [3:0]  row_empty;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  row_boundary_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_byte(wr_byte), .addr(addr), .row_cs(row_cs), .miss(miss),
    .row_empty(row_empty)
  );

  // {addr, expected row_cs, expected miss} with boundaries 10,10,30,40 (hex)
  localparam logic [35:0] VEC [8] = '{
    {31'h0000_0000, 4'b0001, 1'b0},
    {31'h0FFF_FFFF, 4'b0001, 1'b0},
    {31'h1000_0000, 4'b0100, 1'b0},
    {31'h2FFF_FFFF, 4'b0100, 1'b0},
    {31'h3000_0000, 4'b1000, 1'b0},
    {31'h3FFF_FFFF, 4'b1000, 1'b0},
    {31'h4000_0000, 4'b0000, 1'b1},
    {31'h7FFF_FFFF, 4'b0000, 1'b1}
  };
  localparam string VEC_REQ [8] = '{"R3", "R5", "R4", "R4", "R4", "R5", "R6", "R6"};

  task automatic chk(input string req, input logic [3:0] cs_e, input logic m_e,
                     input logic [3:0] em_e);
    total++;
    if (row_cs !== cs_e || miss !== m_e || row_empty !== em_e) begin
      bad++;
      $display("FAIL %s: cs=%b miss=%b empty=%b expected cs=%b miss=%b empty=%b",
               req, row_cs, miss, row_empty, cs_e, m_e, em_e);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_row = r; wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] b0, b1, b2, b3);
    wr(2'd0, b0); wr(2'd1, b1); wr(2'd2, b2); wr(2'd3, b3);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_byte = '0; addr = '0;
    repeat (3) @(negedge clk);
    chk("R1", 4'b0000, 1'b1, 4'b1111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    addr = 31'h5555_5555;
    #1 chk("R1", 4'b0000, 1'b1, 4'b1111);

    // Table walk
    set_all(8'h10, 8'h10, 8'h30, 8'h40);
    for (int i = 0; i < 8; i++) begin
      addr = VEC[i][35:5];
      #1 chk(VEC_REQ[i], VEC[i][4:1], VEC[i][0], 4'b0010);
    end

    // R8: a falling boundary is empty, later base stays at highest
    set_all(8'h20, 8'h10, 8'h30, 8'h30);
    addr = 31'h1800_0000;
    #1 chk("R8", 4'b0001, 1'b0, 4'b1010);
    addr = 31'h2000_0000;
    #1 chk("R8", 4'b0100, 1'b0, 4'b1010);
    addr = 31'h3000_0000;
    #1 chk("R7", 4'b0000, 1'b1, 4'b1010);

    // R10: boundary beyond address space covers all of it
    wr(2'd3, 8'hFF);
    addr = 31'h7FFF_FFFF;
    #1 chk("R10", 4'b1000, 1'b0, 4'b0010);

    // R2: write and decode in the same cycle
    set_all(8'h00, 8'h00, 8'h00, 8'h00);
    @(negedge clk);
    addr = 31'h0100_0000; wr_en = 1'b1; wr_row = 2'd0; wr_byte = 8'h08;
    #2 chk("R2", 4'b0000, 1'b1, 4'b1111);
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk("R2", 4'b0001, 1'b0, 4'b1110);
    addr = 31'h0800_0000;
    #1 chk("R6", 4'b0000, 1'b1, 4'b1110);

    // R7: row 0 empty at 0, row 1 takes addresses from 0
    set_all(8'h00, 8'h04, 8'h04, 8'h04);
    addr = 31'h0000_0000;
    #1 chk("R7", 4'b0010, 1'b0, 4'b1101);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule